// File: doc/BRIEF.md
# Dual Down-Counting Interval Timer

The block holds two independent 16-bit down counters that advance on a shared reference tick enable. Each counter has a mode bit and a rate-select bit. In free mode the counter rolls from zero to all ones and keeps counting down. In reload mode it returns to the value last loaded. The rate-select bit makes a counter step either on every reference tick or only once in every 256 ticks. A single 8-bit prescaler that runs freely is shared by both counters and produces the slow rate.

Software loads a counter through a per-timer load strobe and a shared load value, and reads both counts at all times from a flat count output. When a counter steps while it is at zero, it raises a one-cycle interrupt pulse. Interrupt clearing, bus wrapping and generation of the reference tick belong to the surrounding logic.

Top module: `dual_down_timer`

## Requirements
- R1: A load strobe `ld_i[k]` sets counter k to `ld_val_i` at the next clock edge and also stores that value as the counter's reload value.
- R2: In free mode (mode bit 0), a step taken at count 0 makes the count 0xFFFF. Counting then continues down from there.
- R3: In reload mode (mode bit 1), a step taken at count 0 makes the count equal to the last loaded value.
- R4: With rate-select 1, a counter steps on every cycle in which `tick_i` is high.
- R5: With rate-select 0, a counter steps only on a cycle in which `tick_i` is high and the shared 8-bit prescaler reads 255. The prescaler leaves reset at 0 and adds one on every `tick_i`, so steps come 256 ticks apart.
- R6: A step taken at count 0 sets `irq_o[k]` high for exactly the following cycle, in both modes. Otherwise `irq_o[k]` is low.
- R7: When a load and a step fall in the same cycle, the load wins. The counter takes the load value and no interrupt is raised.
- R8: The control word `cfg_i` places the mode bit of timer 0 at bit 4 and its rate-select at bit 5. Timer 1 has its mode at bit 6 and its rate-select at bit 7. All other bits have no effect.
- R9: Reset clears both counts, both reload values, the interrupts and the prescaler.
- R10: A counter with no step and no load keeps its value.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| tick_i | input | 1 | Reference tick enable |
| cfg_i | input | 8 | Control word: mode and rate-select bits per timer |
| ld_i | input | 2 | Load strobe for each timer |
| ld_val_i | input | 16 | Shared load value |
| cnt_o | output | 32 | Counts, timer 0 in bits 15:0 and timer 1 in bits 31:16 |
| irq_o | output | 2 | Underflow interrupt pulse for each timer |

## Verification
A load can arrive in the same cycle as the underflow step. The bench forces this by loading 0 at rate-select 1 with the tick held high, then strobing a new load in the very next cycle. It expects the loaded value and a quiet interrupt line. Random traffic also produces this collision, and every cycle is compared against a bench model in which the load takes priority.

// File: rtl/ddt_pkg.sv
package ddt_pkg;
  localparam int unsigned CFG_W        = 8;
  localparam int unsigned CFG_MODE_LSB = 4;  // timer k: mode at 4+2k, select at 5+2k
  typedef enum logic {MODE_FREE = 1'b0, MODE_RELOAD = 1'b1} tmr_mode_e;

  function automatic int unsigned mode_bit(int unsigned k);
    return CFG_MODE_LSB + 2 * k;
  endfunction

  function automatic int unsigned sel_bit(int unsigned k);
    return CFG_MODE_LSB + 2 * k + 1;
  endfunction
endpackage

// File: rtl/ddt_prescaler.sv
module ddt_prescaler #(
  parameter int unsigned PRE_W = 8
) (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic tick_i,
  output logic wrap_o
);
  logic [PRE_W-1:0] pre_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)     pre_q <= '0;
    else if (tick_i) pre_q <= pre_q + 1'b1;
  end

  assign wrap_o = tick_i & (&pre_q);
endmodule

// File: rtl/ddt_channel.sv
module ddt_channel #(
  parameter int unsigned CNT_W = 16
) (
  input  logic                clk_i,
  input  logic                rst_ni,
  input  logic                step_i,
  input  ddt_pkg::tmr_mode_e  mode_i,
  input  logic                ld_i,
  input  logic [CNT_W-1:0]    ld_val_i,
  output logic [CNT_W-1:0]    cnt_o,
  output logic [CNT_W-1:0]    rld_o,
  output logic                irq_o
);
  logic [CNT_W-1:0] cnt_q, rld_q, cnt_d;
  logic             irq_q, under;

  assign under = step_i & (cnt_q == '0);

  always_comb begin
    cnt_d = cnt_q;
    if (ld_i)            cnt_d = ld_val_i;
    else if (under)      cnt_d = (mode_i == ddt_pkg::MODE_RELOAD) ? rld_q : '1;
    else if (step_i)     cnt_d = cnt_q - 1'b1;
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      cnt_q <= '0;
      rld_q <= '0;
      irq_q <= 1'b0;
    end else begin
      cnt_q <= cnt_d;
      irq_q <= under & ~ld_i;
      if (ld_i) rld_q <= ld_val_i;
    end
  end

  assign cnt_o = cnt_q;
  assign rld_o = rld_q;
  assign irq_o = irq_q;
endmodule

// File: rtl/dual_down_timer.sv
module dual_down_timer #(
  parameter int unsigned N_TMR = 2,
  parameter int unsigned CNT_W = 16,
  parameter int unsigned PRE_W = 8
) (
  input  logic                    clk_i,
  input  logic                    rst_ni,
  input  logic                    tick_i,
  input  logic [ddt_pkg::CFG_W-1:0] cfg_i,
  input  logic [N_TMR-1:0]        ld_i,
  input  logic [CNT_W-1:0]        ld_val_i,
  output logic [N_TMR*CNT_W-1:0]  cnt_o,
  output logic [N_TMR-1:0]        irq_o
);
  logic                               slow_step;
  logic [N_TMR-1:0]                   step;
  logic [N_TMR-1:0]                   mode;
  logic [N_TMR-1:0][CNT_W-1:0]        cnt;
  logic [N_TMR-1:0][CNT_W-1:0]        rld;

  ddt_prescaler #(.PRE_W(PRE_W)) u_pre (
    .clk_i  (clk_i),
    .rst_ni (rst_ni),
    .tick_i (tick_i),
    .wrap_o (slow_step)
  );

  for (genvar k = 0; k < N_TMR; k++) begin : g_ch
    logic sel;
    assign sel     = cfg_i[ddt_pkg::sel_bit(k)];
    assign mode[k] = cfg_i[ddt_pkg::mode_bit(k)];
    assign step[k] = sel ? tick_i : slow_step;

    ddt_channel #(.CNT_W(CNT_W)) u_ch (
      .clk_i    (clk_i),
      .rst_ni   (rst_ni),
      .step_i   (step[k]),
      .mode_i   (ddt_pkg::tmr_mode_e'(mode[k])),
      .ld_i     (ld_i[k]),
      .ld_val_i (ld_val_i),
      .cnt_o    (cnt[k]),
      .rld_o    (rld[k]),
      .irq_o    (irq_o[k])
    );

    assign cnt_o[k*CNT_W +: CNT_W] = cnt[k];
  end
endmodule

// File: rtl/ddt_checker.sv
module ddt_checker #(
  parameter int unsigned N_TMR = 2,
  parameter int unsigned CNT_W = 16
) (
  input logic                        clk_i,
  input logic                        rst_ni,
  input logic [N_TMR-1:0]            ld_i,
  input logic [CNT_W-1:0]            ld_val_i,
  input logic [N_TMR-1:0]            step,
  input logic [N_TMR-1:0]            mode,
  input logic [N_TMR-1:0][CNT_W-1:0] cnt,
  input logic [N_TMR-1:0][CNT_W-1:0] rld,
  input logic [N_TMR-1:0]            irq_o
);
  for (genvar k = 0; k < N_TMR; k++) begin : g_chk
    AST_LOAD_TAKES: assert property (@(posedge clk_i) disable iff (!rst_ni)
      ld_i[k] |=> (cnt[k] == $past(ld_val_i)) && (rld[k] == $past(ld_val_i))); // R1
    AST_FREE_WRAP: assert property (@(posedge clk_i) disable iff (!rst_ni)
      (step[k] && cnt[k] == '0 && !mode[k] && !ld_i[k]) |=> (cnt[k] == '1)); // R2
    AST_RELOAD: assert property (@(posedge clk_i) disable iff (!rst_ni)
      (step[k] && cnt[k] == '0 && mode[k] && !ld_i[k]) |=> (cnt[k] == $past(rld[k]))); // R3
    AST_IRQ_CAUSE: assert property (@(posedge clk_i) disable iff (!rst_ni)
      irq_o[k] |-> ($past(cnt[k]) == '0) && $past(step[k]) && !$past(ld_i[k])); // R6
    AST_LOAD_QUIET: assert property (@(posedge clk_i) disable iff (!rst_ni)
      ld_i[k] |=> !irq_o[k]); // R7
    AST_HOLD: assert property (@(posedge clk_i) disable iff (!rst_ni)
      (!step[k] && !ld_i[k]) |=> $stable(cnt[k])); // R10
  end
endmodule

bind dual_down_timer ddt_checker #(.N_TMR(N_TMR), .CNT_W(CNT_W)) u_chk (
  .clk_i    (clk_i),
  .rst_ni   (rst_ni),
  .ld_i     (ld_i),
  .ld_val_i (ld_val_i),
  .step     (step),
  .mode     (mode),
  .cnt      (cnt),
  .rld      (rld),
  .irq_o    (irq_o)
);

// File: tb/tb_dual_down_timer.sv
module tb_dual_down_timer;
  localparam int CLK_PERIOD = 10;
  localparam int W = 16;

  logic          clk = 1'b0;
  logic          rst_n = 1'b0;
  logic          tick = 1'b0;
  logic [7:0]    cfg = '0;
  logic [1:0]    ld = '0;
  logic [W-1:0]  ld_val = '0;
  logic [2*W-1:0] cnt;
  logic [1:0]    irq;

  int n_vec = 0, n_bad = 0;
  bit done = 0;

  logic [7:0]   m_pre;
  logic [W-1:0] m_cnt [2];
  logic [W-1:0] m_rld [2];
  logic         m_irq [2];

  always #(CLK_PERIOD/2) clk = ~clk;

  dual_down_timer dut (
    .clk_i(clk), .rst_ni(rst_n), .tick_i(tick), .cfg_i(cfg),
    .ld_i(ld), .ld_val_i(ld_val), .cnt_o(cnt), .irq_o(irq)
  );

  function automatic logic [W-1:0] cnt_of(int k);
    return cnt[k*W +: W];
  endfunction

  task automatic chk(string req, logic [W-1:0] act, logic [W-1:0] exp);
    n_vec++;
    if (act !== exp) begin
      n_bad++;
      $display("FAIL %s: actual %h expected %h at %0t", req, act, exp, $time);
    end
  endtask

  function automatic void model_reset();
    m_pre = '0;
    for (int k = 0; k < 2; k++) begin
      m_cnt[k] = '0; m_rld[k] = '0; m_irq[k] = 1'b0;
    end
  endfunction

  // cfg: mode at bit 4+2k, select at bit 5+2k (R8)
  function automatic void model_step();
    for (int k = 0; k < 2; k++) begin
      logic st;
      st = cfg[5+2*k] ? tick : (tick && m_pre == 8'hFF);
      if (ld[k]) begin
        m_cnt[k] = ld_val; m_rld[k] = ld_val; m_irq[k] = 1'b0;
      end else if (st) begin
        m_irq[k] = (m_cnt[k] == '0);
        m_cnt[k] = (m_cnt[k] == '0) ? (cfg[4+2*k] ? m_rld[k] : 16'hFFFF) : m_cnt[k] - 1'b1;
      end else m_irq[k] = 1'b0;
    end
    if (tick) m_pre = m_pre + 1'b1;
  endfunction

  task automatic cyc(string req);
    @(posedge clk);
    @(negedge clk);
    model_step();
    for (int k = 0; k < 2; k++) begin
      chk(req, cnt_of(k), m_cnt[k]);
      chk(req, {15'd0, irq[k]}, {15'd0, m_irq[k]});
    end
  endtask

  initial begin
    #(CLK_PERIOD * 200000);
    n_bad++;
    $display("FAIL watchdog: actual hung expected done");
    $display("== %0d vectors applied, %0d miscompares ==", n_vec, n_bad);
    $finish;
  end

  initial begin
    int t_first, t_second;
    void'($urandom(32'h5eed_1234));
    model_reset();
    #(CLK_PERIOD * 3);
    @(negedge clk);
    // R9 reset state
    chk("R9", cnt_of(0), 16'h0);
    chk("R9", cnt_of(1), 16'h0);
    chk("R9", {14'd0, irq}, 16'h0);
    rst_n = 1'b1;

    // R1 load both
    ld = 2'b11; ld_val = 16'h0002; cyc("R1");
    ld = 2'b00; chk("R1", cnt_of(1), 16'h0002);

    // R2 free wrap, fast select on timer0 (R4)
    cfg = 8'b0010_0000; tick = 1'b1;
    cyc("R4"); cyc("R4"); cyc("R2");
    chk("R2", cnt_of(0), 16'hFFFF);
    chk("R6", {15'd0, irq[0]}, 16'd1);
    cyc("R6"); chk("R6", {15'd0, irq[0]}, 16'd0);

    // R3 reload mode on timer0
    cfg = 8'b0011_0000; ld = 2'b01; ld_val = 16'h0001; cyc("R1");
    ld = 2'b00; cyc("R3"); cyc("R3");
    chk("R3", cnt_of(0), 16'h0001);
    chk("R6", {15'd0, irq[0]}, 16'd1);

    // R7 collision: underflow step and load in same cycle
    cfg = 8'b0010_0000; ld = 2'b01; ld_val = 16'h0000; cyc("R7");
    ld_val = 16'h0007; cyc("R7");
    ld = 2'b00;
    chk("R7", cnt_of(0), 16'h0007);
    chk("R7", {15'd0, irq[0]}, 16'd0);

    // R5 slow spacing on timer1, R10 hold with tick low
    cfg = 8'b0000_0000; ld = 2'b10; ld_val = 16'd1000; cyc("R1"); ld = 2'b00;
    t_first = -1; t_second = -1;
    for (int i = 0; i < 600 && t_second < 0; i++) begin
      logic [W-1:0] prev;
      prev = cnt_of(1);
      cyc("R5");
      if (cnt_of(1) != prev) begin
        if (t_first < 0) t_first = i; else t_second = i;
      end
    end
    chk("R5", 16'(t_second - t_first), 16'd256);
    tick = 1'b0;
    for (int i = 0; i < 5; i++) cyc("R10");

    // R4 fast spacing on timer1
    cfg = 8'b1000_0000; tick = 1'b1;
    begin
      logic [W-1:0] p;
      p = cnt_of(1); cyc("R4");
      chk("R4", cnt_of(1), p - 16'd1);
    end

    // R8 bits outside the mode/select fields have no effect
    cfg = 8'b1000_1111; cyc("R8"); cyc("R8");

    // random mix
    for (int i = 0; i < 6000; i++) begin
      tick   = ($urandom % 4) != 0;
      ld     = (($urandom % 16) == 0) ? 2'($urandom) : 2'b00;
      ld_val = (($urandom % 3) == 0) ? 16'($urandom % 4) : 16'($urandom % 40);
      if (($urandom % 200) == 0) cfg = 8'($urandom);
      cyc("R6");
    end

    done = 1;
    $display("== %0d vectors applied, %0d miscompares ==", n_vec, n_bad);
    $finish;
  end
endmodule